// File: doc/BRIEF.md
# Output Denormalizer With Clamps

This block takes a three-channel pixel carried at a wide normalized precision of 16 bits per channel and produces the same pixel at a smaller output bit depth. The channels are red or Cr, green or Y, and blue or Cb. A 3-bit mode code selects the target depth. The reduction rounds to the nearest target code and saturates at the top of the range. Each channel is then held inside its own programmable window, given by a floor and a ceiling expressed at the target depth.

The mode code, the clamp values and the pixel come from neighbouring logic. This block has no register interface of its own. A mode code that names no supported depth, whether code 0 or any code from 7 up, makes the block copy the pixel through untouched, with no clamping. One register stage sits on the datapath, and the output is qualified by a valid flag.

Top module: `denorm_out`

## Requirements
- R1: The mode code selects the output depth as follows: 1 gives 6 bits, 2 gives 8, 3 gives 9, 4 gives 10, 5 gives 11 and 6 gives 12. For example, an input of 0x8000 with an open window gives 2^(depth-1).
- R2: In a reducing mode, each channel becomes (x + 2^(15-depth)) >> (16-depth). The result is right-aligned in the low bits of the channel's 16-bit output field, and all bits above the depth are zero. Channel 0 (R/Cr) occupies bits 15:0, channel 1 (G/Y) occupies bits 31:16 and channel 2 (B/Cb) occupies bits 47:32.
- R3: When rounding carries past the top code, the channel saturates to 2^depth-1.
- R4: After reduction, a channel value below its floor is raised to the floor.
- R5: After the floor step, a value above the channel's ceiling is lowered to the ceiling. A ceiling below its floor therefore wins, and the result equals the ceiling.
- R6: Each channel uses only its own floor and ceiling. Changing one channel's pair never affects another channel.
- R7: Mode code 0 passes the 48-bit pixel through unchanged, with no clamping.
- R8: Mode code 7 behaves exactly like mode code 0.
- R9: The output valid is the input valid delayed by one clock cycle. The output pixel reflects the inputs that were present at the edge where that valid was captured.
- R10: In a cycle where the input valid is low, the output pixel holds its previous value.
- R11: While reset is asserted, the output valid and the output pixel are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 48 | Input pixel; bits 15:0 R/Cr, 31:16 G/Y, 47:32 B/Cb |
| mode | input | 3 | Depth select code |
| lo_rcr | input | 12 | Floor for channel 0 at the target depth |
| hi_rcr | input | 12 | Ceiling for channel 0 at the target depth |
| lo_gy | input | 12 | Floor for channel 1 |
| hi_gy | input | 12 | Ceiling for channel 1 |
| lo_bcb | input | 12 | Floor for channel 2 |
| hi_bcb | input | 12 | Ceiling for channel 2 |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 48 | Reduced and clamped pixel, same channel layout |

## Verification
The only state in the block is the output register and its valid bit. A wrong value in either shows up on the ports one cycle after the vector that caused it. A wrong depth decode or a wrong rounding shift shows up as nonzero bits above the target depth, or as codes off by one at the rounding midpoints. A clamp wired to the wrong channel shows up only under windows that differ per channel. The sweeps therefore use distinct windows on each channel, including an inverted one.

// File: rtl/denorm_pkg.sv
package denorm_pkg;

    // Depth-select codes; codes naming no depth act as pass-through.
    typedef enum logic [2:0] {
        DM_PASS = 3'd0,
        DM_D6   = 3'd1,
        DM_D8   = 3'd2,
        DM_D9   = 3'd3,
        DM_D10  = 3'd4,
        DM_D11  = 3'd5,
        DM_D12  = 3'd6,
        DM_RSVD = 3'd7
    } dmode_t;

    typedef enum logic {
        PATH_PASS,
        PATH_REDUCE
    } path_t;

    // Bits per channel for a mode code; 0 means no reduction.
    function automatic int unsigned mode_depth(input logic [2:0] code);
        case (dmode_t'(code))
            DM_D6:   return 6;
            DM_D8:   return 8;
            DM_D9:   return 9;
            DM_D10:  return 10;
            DM_D11:  return 11;
            DM_D12:  return 12;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/denorm_round.sv
// Round-to-nearest reduction of one channel with saturation.
module denorm_round #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12,
    parameter int DW    = $clog2(IN_W + 1)
) (
    input  logic [IN_W-1:0]  x,
    input  logic [DW-1:0]    depth,
    output logic [OUT_W-1:0] y
);
    localparam int SW = IN_W + 1;

    logic [DW-1:0] sh;
    logic [SW-1:0] half;
    logic [SW-1:0] sum;
    logic [SW-1:0] q;
    logic [SW-1:0] lim;

    always_comb begin
        sh   = DW'(IN_W) - depth;
        half = SW'(1) << (sh - DW'(1));
        sum  = {1'b0, x} + half;
        q    = sum >> sh;
        lim  = (SW'(1) << depth) - SW'(1);
        if (depth == '0)
            y = '0;
        else if (q > lim)
            y = lim[OUT_W-1:0];
        else
            y = q[OUT_W-1:0];
    end

endmodule

// File: rtl/denorm_clamp.sv
// Floor then ceiling; the ceiling has the last word.
module denorm_clamp #(
    parameter int OUT_W = 12
) (
    input  logic [OUT_W-1:0] v,
    input  logic [OUT_W-1:0] lo,
    input  logic [OUT_W-1:0] hi,
    output logic [OUT_W-1:0] y
);
    logic [OUT_W-1:0] raised;

    always_comb begin
        raised = (v < lo) ? lo : v;
        y      = (raised > hi) ? hi : raised;
    end

endmodule

// File: rtl/denorm_out.sv
module denorm_out #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [3*IN_W-1:0]   in_pix,
    input  logic [2:0]          mode,
    input  logic [OUT_W-1:0]    lo_rcr,
    input  logic [OUT_W-1:0]    hi_rcr,
    input  logic [OUT_W-1:0]    lo_gy,
    input  logic [OUT_W-1:0]    hi_gy,
    input  logic [OUT_W-1:0]    lo_bcb,
    input  logic [OUT_W-1:0]    hi_bcb,
    output logic                out_valid,
    output logic [3*IN_W-1:0]   out_pix
);
    import denorm_pkg::*;

    localparam int NCH = 3;
    localparam int DW  = $clog2(IN_W + 1);
    localparam int PAD = IN_W - OUT_W;

    logic [DW-1:0]       depth;
    path_t               path;
    logic [OUT_W-1:0]    lo_arr [NCH];
    logic [OUT_W-1:0]    hi_arr [NCH];
    logic [3*IN_W-1:0]   nxt_pix;

    assign lo_arr[0] = lo_rcr;
    assign hi_arr[0] = hi_rcr;
    assign lo_arr[1] = lo_gy;
    assign hi_arr[1] = hi_gy;
    assign lo_arr[2] = lo_bcb;
    assign hi_arr[2] = hi_bcb;

    // Mode decode: a zero depth selects the pass path.
    always_comb begin
        depth = DW'(mode_depth(mode));
        path  = (depth == '0) ? PATH_PASS : PATH_REDUCE;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [OUT_W-1:0] reduced;
        logic [OUT_W-1:0] clamped;

        denorm_round #(.IN_W(IN_W), .OUT_W(OUT_W), .DW(DW)) u_round (
            .x     (in_pix[c*IN_W +: IN_W]),
            .depth (depth),
            .y     (reduced)
        );

        denorm_clamp #(.OUT_W(OUT_W)) u_clamp (
            .v  (reduced),
            .lo (lo_arr[c]),
            .hi (hi_arr[c]),
            .y  (clamped)
        );

        always_comb begin
            unique case (path)
                PATH_PASS:   nxt_pix[c*IN_W +: IN_W] = in_pix[c*IN_W +: IN_W];
                PATH_REDUCE: nxt_pix[c*IN_W +: IN_W] = {{PAD{1'b0}}, clamped};
                default:     nxt_pix[c*IN_W +: IN_W] = in_pix[c*IN_W +: IN_W];
            endcase
        end
    end

    // Single output stage; pixel loads only on valid cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pix   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_pix <= nxt_pix;
        end
    end

endmodule

// File: rtl/denorm_out_chk.sv
module denorm_out_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [3*IN_W-1:0] in_pix,
    input logic [2:0]        mode,
    input logic [OUT_W-1:0]  lo_rcr,
    input logic [OUT_W-1:0]  hi_rcr,
    input logic [OUT_W-1:0]  lo_gy,
    input logic [OUT_W-1:0]  hi_gy,
    input logic [OUT_W-1:0]  lo_bcb,
    input logic [OUT_W-1:0]  hi_bcb,
    input logic              out_valid,
    input logic [3*IN_W-1:0] out_pix
);
    import denorm_pkg::*;

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    function automatic logic fits(input logic [3*IN_W-1:0] p, input int unsigned d);
        logic ok;
        ok = 1'b1;
        for (int c = 0; c < 3; c++)
            if ((int'(p[c*IN_W +: IN_W]) >> d) != 0) ok = 1'b0;
        return ok;
    endfunction

    AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> out_valid == $past(in_valid)); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(in_valid)) |-> $stable(out_pix)); // R10

    AST_PASS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && mode_depth($past(mode)) == 0)
        |-> out_pix == $past(in_pix)); // R7

    AST_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && mode_depth($past(mode)) != 0)
        |-> fits(out_pix, mode_depth($past(mode)))); // R2

    AST_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && mode_depth($past(mode)) != 0)
        |-> (out_pix[IN_W-1:0]        <= IN_W'($past(hi_rcr)) &&
             out_pix[2*IN_W-1:IN_W]   <= IN_W'($past(hi_gy))  &&
             out_pix[3*IN_W-1:2*IN_W] <= IN_W'($past(hi_bcb)))); // R5

    AST_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(in_valid) && mode_depth($past(mode)) != 0)
        |-> (($past(lo_rcr) > $past(hi_rcr) || out_pix[IN_W-1:0]        >= IN_W'($past(lo_rcr))) &&
             ($past(lo_gy)  > $past(hi_gy)  || out_pix[2*IN_W-1:IN_W]   >= IN_W'($past(lo_gy)))  &&
             ($past(lo_bcb) > $past(hi_bcb) || out_pix[3*IN_W-1:2*IN_W] >= IN_W'($past(lo_bcb))))); // R4

endmodule

bind denorm_out denorm_out_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .mode(mode),
    .lo_rcr(lo_rcr), .hi_rcr(hi_rcr), .lo_gy(lo_gy), .hi_gy(hi_gy),
    .lo_bcb(lo_bcb), .hi_bcb(hi_bcb), .out_valid(out_valid), .out_pix(out_pix)
);

// File: tb/denorm_out_bench.sv
module denorm_out_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] in_pix = '0;
    logic [2:0]  mode = '0;
    logic [11:0] lo [3];
    logic [11:0] hi [3];
    logic        out_valid;
    logic [47:0] out_pix;

    int vectors = 0;
    int misses  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    denorm_out u_denorm_out (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix), .mode(mode),
        .lo_rcr(lo[0]), .hi_rcr(hi[0]), .lo_gy(lo[1]), .hi_gy(hi[1]),
        .lo_bcb(lo[2]), .hi_bcb(hi[2]), .out_valid(out_valid), .out_pix(out_pix)
    );

    function automatic int depth_of(input int m);
        case (m)
            1: return 6;  2: return 8;  3: return 9;
            4: return 10; 5: return 11; 6: return 12;
            default: return 0;
        endcase
    endfunction

    function automatic int exp_ch(input int x, input int d, input int l, input int h);
        int q;
        if (d == 0) return x;
        q = (x + (1 << (15 - d))) >> (16 - d);
        if (q > (1 << d) - 1) q = (1 << d) - 1;
        if (q < l) q = l;
        if (q > h) q = h;
        return q;
    endfunction

    task automatic check(input string tag, input logic [47:0] got, input logic [47:0] want);
        vectors++;
        if (got !== want) begin
            misses++;
            $display("FAIL %s: got %h expected %h", tag, got, want);
        end
    endtask

    // Drive one valid vector and check the registered result.
    task automatic apply(input string tag, input int m, input int c0, input int c1, input int c2);
        logic [47:0] want;
        int d;
        @(negedge clk);
        in_valid = 1'b1;
        mode     = 3'(m);
        in_pix   = {16'(c2), 16'(c1), 16'(c0)};
        d = depth_of(m);
        want = {16'(exp_ch(c2, d, int'(lo[2]), int'(hi[2]))),
                16'(exp_ch(c1, d, int'(lo[1]), int'(hi[1]))),
                16'(exp_ch(c0, d, int'(lo[0]), int'(hi[0])))};
        @(posedge clk);
        #1;
        check({tag, " R9 valid"}, {47'd0, out_valid}, 48'd1);
        check(tag, out_pix, want);
    endtask

    task automatic set_window(input int set, input int d);
        int mx;
        mx = (d == 0) ? 4095 : (1 << d) - 1;
        case (set)
            0: for (int c = 0; c < 3; c++) begin lo[c] = 12'd0; hi[c] = 12'd4095; end
            1: begin
                lo[0] = 12'(mx / 4); hi[0] = 12'(3 * mx / 4);
                lo[1] = 12'(mx / 8); hi[1] = 12'(mx / 2);
                lo[2] = 12'(mx / 2); hi[2] = 12'(mx);
            end
            default: begin
                lo[0] = 12'(3 * mx / 4); hi[0] = 12'(mx / 4);
                lo[1] = 12'(mx / 3);     hi[1] = 12'(mx / 3);
                lo[2] = 12'd0;           hi[2] = 12'd0;
            end
        endcase
    endtask

    initial begin
        logic [47:0] held;
        string tag;
        set_window(0, 0);
        repeat (2) @(posedge clk);
        #1;
        check("R11 reset pixel", out_pix, 48'd0);
        check("R11 reset valid", {47'd0, out_valid}, 48'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: midpoint lands on 2^(depth-1)
        for (int m = 1; m <= 6; m++)
            apply("R1 midpoint", m, 32'h8000, 32'h8000, 32'h8000);

        // R2 rounding threshold, R3 saturation at top
        apply("R2 round down", 2, 32'h007F, 32'h017F, 32'h0000);
        apply("R2 round up",   2, 32'h0080, 32'h0180, 32'h0001);
        apply("R3 saturate 8b",  2, 32'hFFFF, 32'hFF80, 32'hFF7F);
        apply("R3 saturate 12b", 6, 32'hFFFF, 32'hFFF8, 32'hFFF7);

        // R10: input valid low, output must hold
        apply("R10 setup", 4, 32'h1234, 32'h5678, 32'h9ABC);
        held = out_pix;
        @(negedge clk);
        in_valid = 1'b0;
        in_pix   = 48'hFFFF_0000_FFFF;
        mode     = 3'd0;
        @(posedge clk);
        #1;
        check("R10 hold pixel", out_pix, held);
        check("R9 valid low", {47'd0, out_valid}, 48'd0);

        // Sweep every mode, three window sets, 256 values per channel.
        for (int m = 0; m < 8; m++) begin
            if (m == 0)      tag = "R7 pass";
            else if (m == 7) tag = "R8 pass";
            else             tag = "R2 R3 R4 R5 R6 reduce";
            for (int s = 0; s < 3; s++) begin
                set_window(s, depth_of(m));
                for (int k = 0; k < 256; k++)
                    apply(tag, m, k * 257, (k * 257) ^ 32'h5A5A, 65535 - k * 251);
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            vectors++;
            misses++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

endmodule